// File: doc/BRIEF.md
# Successive-Approximation Converter Controller

This block is the digital half of a 10-bit successive-approximation analog-to-digital converter. A processor programs it through a small byte-wide register port. It selects an input channel and a reference, chooses a conversion clock rate, starts a conversion and later reads a 10-bit result. The result is presented in two bytes, either right-aligned or left-aligned. The analog parts stay outside the block: the input multiplexer, the DAC, the comparator and the references all connect through plain ports.

While a conversion runs, the block drives a trial code to the external DAC. Once per conversion-clock step it samples a single comparator bit, which must be 1 when the sampled input is at or above the DAC level. The conversion clock is an enable pulse derived from the system clock, so the whole block stays in one clock domain. When a conversion finishes, the block latches the result, sets a sticky completion flag and, if enabled, raises an interrupt request.

The register port is a plain addressed bus with no handshake. Every write completes in the cycle it is presented, and reads are combinational from the address, so the bus never applies back-pressure. The analog data path is not a stream: the trial code and the comparator bit are level signals that are valid for a whole conversion step.

Top module: `sar_adc_ctrl`

## Requirements
- R1: After reset, every register reads 0x00 (select at address 0, control at address 1, result low byte at address 2, result high byte at address 3), `irq` is 0, `mux_sel` is 0 (single-ended channel 0) and `ref_sel` is 0 (external reference pin).
- R2: The select register (address 0) holds the channel in bits [3:0], the left-align bit in bit 5 and the reference choice in bits [7:6]. Bit 4 reads 0. The channel and reference fields drive `mux_sel` and `ref_sel` directly.
- R3: The control register (address 1) holds the prescale code in bits [2:0]. The division is 2 for codes 0 and 1, and 2^code for codes 2 to 7. A conversion takes exactly 11 divided-clock steps (one sample step and ten bit decisions), so busy clears exactly 11×division system cycles after the clock edge that accepted the start.
- R4: The enable bit is control bit 7. A start written while the enable bit is 0 (counting the value written in the same write) is ignored: busy stays 0, the completion flag is not set and the result does not change.
- R5: Writing 1 to control bit 6 (the start bit) with the block enabled and idle begins a conversion. Bit 6 reads 1 while the conversion runs and returns to 0 by itself when it ends.
- R6: Bits are decided from the MSB down. The first trial code on `dac_code` after the sample step is 0x200. At each decision the trial bit is kept when `cmp_ge` is 1 and cleared otherwise, so the final result equals the input level the comparator represents.
- R7: The completion flag (control bit 4) is set when a conversion ends. Writing 1 to bit 4 clears it, and writing 0 leaves it unchanged. `irq` equals the flag ANDed with the interrupt-enable bit (control bit 3).
- R8: With the left-align bit at 0, the low byte holds result[7:0] and the high byte holds result[9:8] in its bits [1:0]. With the left-align bit at 1, the high byte holds result[9:2] and the low byte holds result[1:0] in its bits [7:6]. All other bits read 0.
- R9: The result bytes change only at the end of a conversion. A read during a conversion returns the previous result.
- R10: Clearing the enable bit during a conversion aborts it at once. Busy reads 0, the completion flag is not set and the result is kept.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| mux_sel | output | 4 | Channel select to the analog multiplexer |
| ref_sel | output | 2 | Reference select to the analog front end |
| dac_code | output | 10 | Trial code for the external DAC |
| cmp_ge | input | 1 | Comparator: 1 when the input is at or above the DAC level |
| irq | output | 1 | Interrupt request, level |

## Verification
The hardest situations to reach are the two that occur inside a running conversion: a read that must still return the previous result, and an abort that must leave both the flag and the result untouched. The bench selects the slowest prescale code, which gives a window of more than 1400 cycles. It reads the result bytes a few hundred cycles into that window, then clears the enable bit before the conversion can end. Exact step timing is checked by counting cycles from the accepted start edge to the fall of busy for several prescale codes, and the first trial code is sampled at the edge where the sample step ends.

// File: rtl/sar_pkg.sv
package sar_pkg;
  localparam int RES_W   = 10;
  localparam int BYTE_W  = 8;
  localparam int PS_W    = 3;

  localparam logic [1:0] A_SEL  = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_LO   = 2'd2;
  localparam logic [1:0] A_HI   = 2'd3;

  localparam int B_EN    = 7;
  localparam int B_START = 6;
  localparam int B_FLAG  = 4;
  localparam int B_IE    = 3;
  localparam int B_LEFT  = 5;

  typedef enum logic [1:0] {
    S_IDLE   = 2'd0,
    S_SAMPLE = 2'd1,
    S_CONV   = 2'd2
  } sar_state_t;
endpackage

// File: rtl/sar_prescaler.sv
module sar_prescaler #(
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [CODE_W-1:0] code,
  output logic              tick
);
  localparam int CNT_W = (1 << CODE_W) - 1;

  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  lim;
  logic [CODE_W-1:0] sh;

  always_comb begin
    sh   = (code == '0) ? CODE_W'(1) : code;
    lim  = ({{(CNT_W-1){1'b0}}, 1'b1} << sh) - 1'b1;
    tick = run && (cnt_q == lim);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!run)     cnt_q <= '0;
    else if (tick)     cnt_q <= '0;
    else               cnt_q <= cnt_q + 1'b1;
  end

  // smallest division is 2, so ticks never come back to back
  p_tick_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/sar_engine.sv
module sar_engine
  import sar_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         start,
  input  logic         tick,
  input  logic         cmp_ge,
  output logic         busy,
  output logic [W-1:0] dac_code,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int IDX_W = $clog2(W);
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(W - 1);

  sar_state_t       st_q;
  logic [W-1:0]     code_q;
  logic [W-1:0]     code_nx;
  logic [IDX_W-1:0] idx_q;

  always_comb begin
    code_nx = code_q;
    code_nx[idx_q] = cmp_ge;
    if (idx_q != '0) code_nx[idx_q - 1'b1] = 1'b1;
  end

  assign busy     = (st_q != S_IDLE);
  assign done     = (st_q == S_CONV) && tick && (idx_q == '0);
  assign result   = code_nx;
  assign dac_code = code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      code_q <= '0;
      idx_q  <= '0;
    end else if (!en) begin
      st_q <= S_IDLE;
    end else begin
      case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_SAMPLE;
          code_q <= '0;
        end
        S_SAMPLE: if (tick) begin
          st_q   <= S_CONV;
          code_q <= {1'b1, {(W-1){1'b0}}};
          idx_q  <= TOP_IDX;
        end
        S_CONV: if (tick) begin
          code_q <= code_nx;
          if (idx_q == '0) st_q <= S_IDLE;
          else             idx_q <= idx_q - 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  p_msb_first_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == S_CONV && $past(st_q) == S_SAMPLE) |-> (code_q == {1'b1, {(W-1){1'b0}}}));

  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);
endmodule

// File: rtl/sar_align.sv
module sar_align #(
  parameter int W = 10,
  parameter int B = 8
) (
  input  logic [W-1:0] res,
  input  logic         left,
  output logic [B-1:0] lo,
  output logic [B-1:0] hi
);
  localparam int PAD = 2 * B - W;

  logic [2*B-1:0] wide;

  always_comb begin
    if (left) wide = {res, {PAD{1'b0}}};
    else      wide = {{PAD{1'b0}}, res};
    lo = wide[B-1:0];
    hi = wide[2*B-1:B];
  end
endmodule

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl
  import sar_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  bus_addr,
  input  logic        bus_wr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  output logic [3:0]  mux_sel,
  output logic [1:0]  ref_sel,
  output logic [9:0]  dac_code,
  input  logic        cmp_ge,
  output logic        irq
);
  logic [3:0]       chan_q;
  logic [1:0]       ref_q;
  logic             left_q;
  logic             en_q, ie_q, flag_q;
  logic [PS_W-1:0]  ps_q;
  logic [RES_W-1:0] res_q;

  logic wr_sel, wr_ctrl, en_d, start_p;
  logic busy, tick, done;
  logic [RES_W-1:0]  res_nx;
  logic [BYTE_W-1:0] lo_b, hi_b;
  logic unused_bits;

  assign wr_sel  = bus_wr && (bus_addr == A_SEL);
  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign en_d    = wr_ctrl ? bus_wdata[B_EN] : en_q;
  assign start_p = wr_ctrl && bus_wdata[B_START];
  assign unused_bits = ^{bus_wdata[4], bus_wdata[5]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_q <= '0;
      ref_q  <= '0;
      left_q <= 1'b0;
    end else if (wr_sel) begin
      chan_q <= bus_wdata[3:0];
      ref_q  <= bus_wdata[7:6];
      left_q <= bus_wdata[B_LEFT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
      ie_q <= 1'b0;
      ps_q <= '0;
    end else if (wr_ctrl) begin
      en_q <= bus_wdata[B_EN];
      ie_q <= bus_wdata[B_IE];
      ps_q <= bus_wdata[PS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                               flag_q <= 1'b0;
    else if (done)                            flag_q <= 1'b1;
    else if (wr_ctrl && bus_wdata[B_FLAG])    flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    res_q <= '0;
    else if (done) res_q <= res_nx;
  end

  sar_prescaler #(.CODE_W(PS_W)) u_div (
    .clk(clk), .rst_n(rst_n), .run(busy), .code(ps_q), .tick(tick)
  );

  sar_engine #(.W(RES_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .en(en_d), .start(start_p), .tick(tick),
    .cmp_ge(cmp_ge), .busy(busy), .dac_code(dac_code), .done(done),
    .result(res_nx)
  );

  sar_align #(.W(RES_W), .B(BYTE_W)) u_align (
    .res(res_q), .left(left_q), .lo(lo_b), .hi(hi_b)
  );

  always_comb begin
    case (bus_addr)
      A_SEL:   bus_rdata = {ref_q, left_q, 1'b0, chan_q};
      A_CTRL:  bus_rdata = {en_q, busy, 1'b0, flag_q, ie_q, ps_q};
      A_LO:    bus_rdata = lo_b;
      default: bus_rdata = hi_b;
    endcase
  end

  assign mux_sel = chan_q;
  assign ref_sel = ref_q;
  assign irq     = flag_q && ie_q;

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> flag_q);

  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q));

  p_start_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> en_q);
endmodule

// File: tb/sar_adc_ctrl_test.sv
module sar_adc_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [3:0] mux_sel;
  logic [1:0] ref_sel;
  logic [9:0] dac_code;
  logic       cmp_ge;
  logic       irq;
  logic [9:0] vin = '0;

  int n_chk = 0, n_fail = 0;
  logic [9:0] exp_q[$];
  logic [9:0] last_res = '0;

  always #5 clk = ~clk;
  assign cmp_ge = (vin >= dac_code);

  sar_adc_ctrl uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mux_sel(mux_sel),
    .ref_sel(ref_sel), .dac_code(dac_code), .cmp_ge(cmp_ge), .irq(irq)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input bit en, input bit st, input bit clr,
                                      input bit ie, input logic [2:0] ps);
    return {en, st, 1'b0, clr, ie, ps};
  endfunction

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] c;
    for (int k = 0; k < 5000; k++) begin
      rd(2'd1, c);
      if (!c[6]) break;
    end
  endtask

  // monitor side of the scoreboard: pop the expected code, compare bytes
  task automatic check_result(input bit left, input string req);
    logic [9:0] e;
    logic [7:0] lo, hi;
    logic [15:0] w;
    e = exp_q.pop_front();
    w = left ? {e, 6'b0} : {6'b0, e};
    rd(2'd2, lo);
    rd(2'd3, hi);
    check(lo == w[7:0], req, lo, w[7:0]);
    check(hi == w[15:8], req, hi, w[15:8]);
    last_res = e;
  endtask

  // driver side: set the level, push the expectation, start and wait
  task automatic run_conv(input logic [9:0] v, input logic [2:0] ps, input bit ie);
    logic [7:0] c;
    vin = v;
    exp_q.push_back(v);
    wr(2'd1, ctrl(1, 1, 1, ie, ps));
    wait_idle();
    rd(2'd1, c);
    check(c[4] == 1'b1, "R7 flag set", c[4], 1);
    check(irq == ie, "R7 irq", irq, ie);
  endtask

  task automatic measure(input logic [2:0] ps, input int div);
    int n, got;
    logic [9:0] first;
    vin = 10'h3FF;
    exp_q.push_back(10'h3FF);
    wr(2'd1, ctrl(1, 1, 1, 0, ps));
    bus_addr = 2'd1;
    n = 0; got = -1; first = '0;
    for (int k = 0; k < 3000; k++) begin
      @(posedge clk);
      #2;
      n++;
      if (n == 1) check(bus_rdata[6] == 1'b1, "R5 busy reads 1", bus_rdata[6], 1);
      if (n == div) first = dac_code;
      if (!bus_rdata[6]) begin got = n; break; end
    end
    check(got == 11 * div, "R3 conversion length", got, 11 * div);
    check(first == 10'h200, "R6 first trial", first, 10'h200);
    check_result(1'b0, "R6 result");
  endtask

  initial begin
    #(200000 * 10);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d, lo, hi;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], d);
      check(d == 8'h00, "R1 reset register", d, 0);
    end
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(mux_sel == 4'd0 && ref_sel == 2'd0, "R1 selects", {ref_sel, mux_sel}, 0);

    wr(2'd0, 8'hD5);
    rd(2'd0, d);
    check(d == 8'hC5, "R2 select readback", d, 8'hC5);
    check(mux_sel == 4'h5, "R2 mux_sel", mux_sel, 5);
    check(ref_sel == 2'h3, "R2 ref_sel", ref_sel, 3);
    wr(2'd0, 8'h00);

    vin = 10'h155;
    wr(2'd1, ctrl(0, 1, 0, 1, 0));
    repeat (60) @(posedge clk);
    rd(2'd1, d);
    check(d[6] == 1'b0, "R4 no busy when disabled", d[6], 0);
    check(d[4] == 1'b0, "R4 no flag when disabled", d[4], 0);
    rd(2'd2, lo);
    check(lo == 8'h00, "R4 result untouched", lo, 0);

    measure(3'd0, 2);
    measure(3'd1, 2);
    measure(3'd3, 8);
    measure(3'd7, 128);

    run_conv(10'h000, 3'd0, 0); check_result(1'b0, "R6 zero");
    run_conv(10'h3FF, 3'd2, 0); check_result(1'b0, "R6 full");
    run_conv(10'h200, 3'd0, 0); check_result(1'b0, "R6 mid");
    run_conv(10'h1FF, 3'd0, 0); check_result(1'b0, "R6 below mid");
    run_conv(10'h2AA, 3'd1, 0); check_result(1'b0, "R6 alternating");
    run_conv(10'h155, 3'd0, 0); check_result(1'b0, "R6 alternating inv");

    wr(2'd0, 8'h20);
    run_conv(10'h2D3, 3'd0, 0); check_result(1'b1, "R8 left aligned");
    wr(2'd0, 8'h00);
    exp_q.push_back(10'h2D3);
    check_result(1'b0, "R8 right aligned");

    run_conv(10'h0F0, 3'd0, 1); check_result(1'b0, "R7 result");
    wr(2'd1, ctrl(1, 0, 0, 1, 0));
    rd(2'd1, d);
    check(d[4] == 1'b1 && irq, "R7 write 0 keeps flag", {d[4], irq}, 3);
    wr(2'd1, ctrl(1, 0, 1, 1, 0));
    rd(2'd1, d);
    check(d[4] == 1'b0, "R7 w1c clears flag", d[4], 0);
    check(irq == 1'b0, "R7 irq drops", irq, 0);

    vin = 10'h3C3;
    wr(2'd1, ctrl(1, 1, 1, 0, 7));
    repeat (300) @(posedge clk);
    rd(2'd1, d);
    check(d[6] == 1'b1, "R5 busy mid conversion", d[6], 1);
    rd(2'd2, lo);
    rd(2'd3, hi);
    check({hi[1:0], lo} == last_res, "R9 no partial result", {hi[1:0], lo}, last_res);
    wr(2'd1, ctrl(0, 0, 0, 0, 7));
    rd(2'd1, d);
    check(d[6] == 1'b0, "R10 abort clears busy", d[6], 0);
    repeat (2000) @(posedge clk);
    rd(2'd1, d);
    check(d[4] == 1'b0, "R10 no flag after abort", d[4], 0);
    rd(2'd2, lo);
    rd(2'd3, hi);
    check({hi[1:0], lo} == last_res, "R10 result kept", {hi[1:0], lo}, last_res);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule